// File: doc/BRIEF.md
# Dual-Standard FSK Tone Modulator

This block turns a serial bit stream into a sampled frequency-shift-keyed carrier for 300 bit/s modem operation. Two mode inputs choose the tone plan: one picks between the Bell 103 and V.21 frequency sets, and the other picks the originating or answering side of the call. The data bit then selects the mark tone or the space tone. The carrier comes from a phase accumulator that advances once for each sample-rate enable. The accumulator's top bits address a computed sine table. The resulting signed sample is registered and comes out with a one-cycle valid strobe.

A change of data, direction or standard only changes the phase step, so the waveform never jumps in phase. A transmit-enable input squelches the output to zero and holds the phase. While the transmitter is enabled, a bypass flag tells the surrounding data path to route around its rate converter and scrambler, since neither of them applies to FSK traffic.

Top module: `fsk_tone_mod`

## Requirements
- R1: With `v21_sel`=0 and `answer`=0, the phase step is round(f·2^24/9600), where f is 1270 Hz for mark and 1070 Hz for space.
- R2: With `v21_sel`=0 and `answer`=1, f is 2225 Hz for mark and 2025 Hz for space.
- R3: With `v21_sel`=1 and `answer`=0, f is 980 Hz for mark and 1180 Hz for space.
- R4: With `v21_sel`=1 and `answer`=1, f is 1650 Hz for mark and 1850 Hz for space.
- R5: `data_bit`=1 selects the mark tone and `data_bit`=0 selects the space tone.
- R6: A change of `data_bit`, `answer` or `v21_sel` never resets the 24-bit phase. The next sample continues from the accumulated phase.
- R7: On a clock edge where `sample_en` and `tx_en` are both 1, `sample_out` becomes round(2047·sin(2π·p/64)), where p is bits 23:18 of the phase before that step, and the phase then advances by one step. `sample_valid` is 1 for exactly the cycle that follows each `sample_en`.
- R8: On a `sample_en` edge with `tx_en`=0, `sample_out` becomes 0, the phase is held, and `sample_valid` still pulses.
- R9: `fsk_bypass` equals `tx_en` at all times.
- R10: While `rst_n` is 0, the phase, `sample_out` and `sample_valid` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One-cycle pulse at the 9600 Hz sample rate |
| tx_en | input | 1 | Transmitter enable; low squelches the output |
| data_bit | input | 1 | Serial data bit (1 = mark, 0 = space) |
| answer | input | 1 | Call direction: 0 = originate, 1 = answer |
| v21_sel | input | 1 | Standard: 0 = Bell 103, 1 = V.21 |
| sample_out | output | 12 | Signed carrier sample |
| sample_valid | output | 1 | Strobe marking a new sample |
| fsk_bypass | output | 1 | Tells the data path to bypass the rate converter and scrambler |

## Verification
The bench changes the data bit, the direction and the standard between samples, and also in the middle of a run. A design that reset or reloaded its phase on a tone change would show an output discontinuity at that sample, where the model keeps accumulating. Each of the eight tones is held long enough for its step to wrap the accumulator. A swapped mark/space pair or a wrongly rounded step therefore drifts visibly away from the model. The bench also squelches and re-enables the transmitter mid-stream. A design that kept advancing the phase while squelched, or that failed to zero the output, diverges after re-enable.

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod #(
  parameter int ACC_W      = 24,
  parameter int LUT_AW     = 6,
  parameter int OUT_W      = 12,
  parameter int SAMPLE_HZ  = 9600,
  parameter int BELL_O_MK  = 1270,
  parameter int BELL_O_SP  = 1070,
  parameter int BELL_A_MK  = 2225,
  parameter int BELL_A_SP  = 2025,
  parameter int V21_O_MK   = 980,
  parameter int V21_O_SP   = 1180,
  parameter int V21_A_MK   = 1650,
  parameter int V21_A_SP   = 1850
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic                    tx_en,
  input  logic                    data_bit,
  input  logic                    answer,
  input  logic                    v21_sel,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_valid,
  output logic                    fsk_bypass
);
  localparam int LUT_N = 1 << LUT_AW;
  localparam int AMP   = (1 << (OUT_W-1)) - 1;
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic [ACC_W-1:0] step_of(input longint f);
    longint s;
    s = ((f << ACC_W) + SAMPLE_HZ/2) / SAMPLE_HZ;
    return s[ACC_W-1:0];
  endfunction

  function automatic logic signed [OUT_W-1:0] sine_of(input int k);
    real r;
    int  v;
    r = AMP * $sin(TWO_PI * k / LUT_N);
    v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
    return v[OUT_W-1:0];
  endfunction

  localparam logic [ACC_W-1:0] S_BOM = step_of(BELL_O_MK);
  localparam logic [ACC_W-1:0] S_BOS = step_of(BELL_O_SP);
  localparam logic [ACC_W-1:0] S_BAM = step_of(BELL_A_MK);
  localparam logic [ACC_W-1:0] S_BAS = step_of(BELL_A_SP);
  localparam logic [ACC_W-1:0] S_VOM = step_of(V21_O_MK);
  localparam logic [ACC_W-1:0] S_VOS = step_of(V21_O_SP);
  localparam logic [ACC_W-1:0] S_VAM = step_of(V21_A_MK);
  localparam logic [ACC_W-1:0] S_VAS = step_of(V21_A_SP);

  logic signed [OUT_W-1:0] lut [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    assign lut[k] = sine_of(k);
  end

  logic [ACC_W-1:0] phase, step;
  wire advance = sample_en && tx_en;

  always_comb begin
    case ({v21_sel, answer, data_bit})
      3'b001:  step = S_BOM;
      3'b000:  step = S_BOS;
      3'b011:  step = S_BAM;
      3'b010:  step = S_BAS;
      3'b101:  step = S_VOM;
      3'b100:  step = S_VOS;
      3'b111:  step = S_VAM;
      default: step = S_VAS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= '0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= sample_en;
      if (advance) begin
        phase      <= phase + step;
        sample_out <= lut[phase[ACC_W-1 -: LUT_AW]];
      end else if (sample_en) begin
        sample_out <= '0;
      end
    end
  end

  assign fsk_bypass = tx_en;

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> sample_valid);
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> !sample_valid);
  assert_amp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out <= AMP) && (sample_out >= -AMP));
  assert_squelch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !tx_en) |=> (sample_out == '0));
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(phase));
  assert_phase_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (phase != $past(phase)));
endmodule

// File: tb/fsk_tone_mod_bench.sv
module fsk_tone_mod_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_en = 1'b0, tx_en = 1'b0, data_bit = 1'b0, answer = 1'b0, v21_sel = 1'b0;
  logic signed [11:0] sample_out;
  logic sample_valid, fsk_bypass;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsk_tone_mod u_fsk_tone_mod (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tx_en(tx_en),
    .data_bit(data_bit), .answer(answer), .v21_sel(v21_sel),
    .sample_out(sample_out), .sample_valid(sample_valid), .fsk_bypass(fsk_bypass));

  function automatic int tone_hz(bit v, bit a, bit d);
    int t[8] = '{1070, 1270, 2025, 2225, 1180, 980, 1850, 1650};
    return t[{v, a, d}];
  endfunction

  function automatic longint step_ref(int f);
    return longint'($rtoi(f * 16777216.0 / 9600.0 + 0.5));
  endfunction

  function automatic int sine_ref(int p);
    real r = 2047.0 * $sin(2.0 * 3.141592653589793 * p / 64.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
  endfunction

  longint m_phase = 0;
  int exp_out = 0;
  bit exp_valid = 0;
  string exp_tag = "R10";
  bit last_v = 0, last_a = 0, last_d = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; exp_out = 0; exp_valid = 0; exp_tag = "R10";
    end else begin
      exp_valid = sample_en;
      if (sample_en && tx_en) begin
        exp_out = sine_ref(int'(m_phase >> 18));
        if ({v21_sel, answer, data_bit} != {last_v, last_a, last_d}) exp_tag = "R6";
        else case ({v21_sel, answer})
          2'b00: exp_tag = "R1/R5";
          2'b01: exp_tag = "R2/R5";
          2'b10: exp_tag = "R3/R5";
          default: exp_tag = "R4/R5";
        endcase
        m_phase = (m_phase + step_ref(tone_hz(v21_sel, answer, data_bit))) & 64'hFFFFFF;
        {last_v, last_a, last_d} = {v21_sel, answer, data_bit};
      end else if (sample_en) begin
        exp_out = 0; exp_tag = "R8";
      end
    end
  end

  task automatic check_now();
    tests++;
    if (int'(sample_out) != exp_out) begin
      fails++;
      $display("FAIL %s sample_out=%0d expected %0d (cycle %0d)", exp_tag, sample_out, exp_out, cyc);
    end
    tests++;
    if (sample_valid !== exp_valid) begin
      fails++;
      $display("FAIL R7 sample_valid=%0b expected %0b (cycle %0d)", sample_valid, exp_valid, cyc);
    end
    tests++;
    if (fsk_bypass !== tx_en) begin
      fails++;
      $display("FAIL R9 fsk_bypass=%0b expected %0b (cycle %0d)", fsk_bypass, tx_en, cyc);
    end
  endtask

  task automatic run(int n, bit te, bit v, bit a, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check_now();
      sample_en = (cyc % 4 == 0);
      tx_en = te; v21_sel = v; answer = a;
      case (pat)
        0: data_bit = 1'b0;
        1: data_bit = 1'b1;
        2: data_bit = ((cyc / 128) % 2) == 1;
        default: data_bit = ((cyc * 7 + cyc / 5) % 3) == 0;
      endcase
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    run(20, 0, 0, 0, 0);
    for (int m = 0; m < 4; m++) begin
      run(400, 1, m[1], m[0], 1);
      run(400, 1, m[1], m[0], 0);
      run(400, 1, m[1], m[0], 2);
    end
    run(300, 1, 0, 1, 3);
    run(300, 1, 1, 0, 3);
    run(60, 0, 1, 0, 3);
    run(200, 1, 1, 1, 2);
    for (int k = 0; k < 16; k++) run(24, 1, k[0], k[1], 3);
    run(40, 0, 0, 0, 1);
    run(100, 1, 0, 0, 1);
    rst_n = 1'b0;
    run(8, 1, 0, 0, 1);
    rst_n = 1'b1;
    run(100, 1, 1, 1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule